// File: doc/BRIEF.md
# Platform Window Aligned Transaction Gate

This block sits between a device's request sources and its upstream port. It decides, cycle by cycle, which memory transfers and interrupts leave the device, based on the platform's current power window. There are three windows: a low-power idle window, a buffer flush/fill window in which the memory path is open, and a fully active processor window in which both memory traffic and interrupts are welcome. The window comes in already decoded, either as a level from a side-band wire decoder or as a code carried by a received message. A select input chooses which of the two sources is used.

Each request is marked urgent or deferrable. Urgent requests are granted on the next cycle whatever the window. Deferrable requests wait in an ordered queue. When the window allows the request at the head of the queue, the queue empties as one back-to-back burst instead of sending requests out one at a time. A programmable residency limit pushes out an entry that has waited too long. A full queue makes an incoming deferrable request pass straight through and sets a sticky overflow flag. The device's DMA engine and data buffers, and the decoding of the wake wire's waveform, are outside this block.

Top module: `pwg_txn_gate`

## Requirements
- R1: A request with `req_crit`=1 is granted in the cycle after it is presented, with `gnt_cause`=0, in every window and at every queue fill level.
- R2: Window codes are 00 idle, 01 flush/fill and 10 processor-active; code 11 is taken as idle. `win_now` shows the selected window one cycle after the input, and no request is released because of the window while `win_now` is idle.
- R3: `req_kind`=0 marks a memory request and 1 an interrupt. A deferrable memory request may be released in flush/fill or processor-active. A deferrable interrupt may be released only in processor-active.
- R4: With `use_msg`=1 the window is the last code received with `msg_vld` (idle after reset), and `wire_win` has no effect. With `use_msg`=0 the window follows `wire_win`.
- R5: A deferrable request that arrives while the queue is empty and the window allows its kind is granted in the next cycle with `gnt_cause`=1. Otherwise it is queued, and `q_count` rises by one.
- R6: Queued requests leave in arrival order. A head entry that the window does not allow blocks every entry behind it. A new deferrable request is queued behind existing entries while the queue is not empty.
- R7: Once the head entry is allowed, queued entries are granted on consecutive cycles, one per cycle. The first grant comes two cycles after the window input changes.
- R8: A head entry whose residency reaches `age_limit` cycles is released even if the window does not allow it, with `gnt_cause`=2. An entry queued at clock edge E is granted at edge E+`age_limit`+1.
- R9: A deferrable request that arrives while `q_count` equals the depth is granted in the next cycle with `gnt_cause`=3. It sets `q_overflow`, which stays set until reset.
- R10: At most one grant is made per cycle. An incoming urgent or overflowing request takes the slot ahead of a queue release, and the queue resumes in the following cycle.
- R11: During and right after reset there is no grant, `q_count` is 0, `q_overflow` is 0 and `win_now` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_msg | input | 1 | 1 selects the message-carried window, 0 the wire-decoded window |
| wire_win | input | 2 | Window code from the wire decoder |
| msg_vld | input | 1 | Pulse: a window message has arrived |
| msg_win | input | 2 | Window code carried by the message |
| age_limit | input | AGE_W | Residency limit in cycles for queued entries |
| req_vld | input | 1 | A request is presented this cycle |
| req_crit | input | 1 | 1 urgent, 0 deferrable |
| req_kind | input | 1 | 0 memory transfer, 1 interrupt |
| req_tag | input | TAG_W | Request identifier |
| gnt_vld | output | 1 | A request is granted this cycle |
| gnt_kind | output | 1 | Kind of the granted request |
| gnt_tag | output | TAG_W | Identifier of the granted request |
| gnt_cause | output | 2 | 0 urgent, 1 window, 2 aged, 3 overflow |
| win_now | output | 2 | Window currently in force |
| q_count | output | clog2(DEPTH+1) | Entries waiting in the queue |
| q_overflow | output | 1 | Sticky: a deferrable request arrived at a full queue |

## Verification
A wrong queue pointer or occupancy count shows up at the grant port as reordered or duplicated tags, or as a burst that stops early. The scoreboard catches it at the first grant after the fault. A wrong window decision shows up as a grant whose cause does not fit `win_now` one cycle earlier, which is visible in the same cycle as the grant. A wrong residency counter moves an aged release off its exact cycle, so it is checked at edge E+limit+1 and at the cycle before it. A lost overflow flag shows as `q_overflow` falling while the queue drains.

// File: rtl/pwg_pkg.sv
`timescale 1ns/1ps
package pwg_pkg;
  localparam logic [1:0] PW_IDLE  = 2'b00;
  localparam logic [1:0] PW_FLUSH = 2'b01;
  localparam logic [1:0] PW_PROC  = 2'b10;

  localparam logic KIND_MEM = 1'b0;
  localparam logic KIND_IRQ = 1'b1;

  localparam logic [1:0] CAUSE_CRIT  = 2'd0;
  localparam logic [1:0] CAUSE_WIN   = 2'd1;
  localparam logic [1:0] CAUSE_AGED  = 2'd2;
  localparam logic [1:0] CAUSE_SPILL = 2'd3;

  // the unused code folds to the lowest-power window
  function automatic logic [1:0] pw_normalize(input logic [1:0] code);
    return (code == 2'b11) ? PW_IDLE : code;
  endfunction

  // memory traffic needs an open memory path, interrupts need active cores
  function automatic logic pw_allows(input logic [1:0] win, input logic kind);
    if (kind == KIND_IRQ) return win == PW_PROC;
    return (win == PW_FLUSH) || (win == PW_PROC);
  endfunction
endpackage

// File: rtl/pwg_window_src.sv
`timescale 1ns/1ps
module pwg_window_src
  import pwg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       use_msg,
  input  logic [1:0] wire_win,
  input  logic       msg_vld,
  input  logic [1:0] msg_win,
  output logic [1:0] win_now
);
  logic [1:0] msg_hold_q;
  logic [1:0] msg_code;
  logic [1:0] win_d;

  assign msg_code = pw_normalize(msg_win);

  always_comb begin
    if (use_msg) win_d = msg_vld ? msg_code : msg_hold_q;
    else         win_d = pw_normalize(wire_win);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_hold_q <= PW_IDLE;
      win_now    <= PW_IDLE;
    end else begin
      if (msg_vld) msg_hold_q <= msg_code;
      win_now <= win_d;
    end
  end
endmodule

// File: rtl/pwg_defer_fifo.sv
`timescale 1ns/1ps
module pwg_defer_fifo #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int AGE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [TAG_W-1:0]            push_tag,
  input  logic                        push_kind,
  input  logic                        pop,
  output logic                        head_vld,
  output logic [TAG_W-1:0]            head_tag,
  output logic                        head_kind,
  output logic [AGE_W-1:0]            head_age,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             slot_occ  [DEPTH];
  logic [TAG_W-1:0] slot_tag  [DEPTH];
  logic             slot_kind [DEPTH];
  logic [AGE_W-1:0] slot_age  [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             occ_q;
    logic [TAG_W-1:0] tag_q;
    logic             kind_q;
    logic [AGE_W-1:0] age_q;
    logic             wr_here;
    logic             rd_here;

    assign wr_here = push && (wr_ptr == PTR_W'(g));
    assign rd_here = pop  && (rd_ptr == PTR_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q  <= 1'b0;
        tag_q  <= '0;
        kind_q <= 1'b0;
        age_q  <= '0;
      end else if (wr_here) begin
        occ_q  <= 1'b1;
        tag_q  <= push_tag;
        kind_q <= push_kind;
        age_q  <= '0;
      end else begin
        if (rd_here) occ_q <= 1'b0;
        if (occ_q && !rd_here && age_q != AGE_MAX) age_q <= age_q + 1'b1;
      end
    end

    assign slot_occ[g]  = occ_q;
    assign slot_tag[g]  = tag_q;
    assign slot_kind[g] = kind_q;
    assign slot_age[g]  = age_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_vld  = slot_occ[rd_ptr];
  assign head_tag  = slot_tag[rd_ptr];
  assign head_kind = slot_kind[rd_ptr];
  assign head_age  = slot_age[rd_ptr];
  assign full      = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/pwg_release_pick.sv
`timescale 1ns/1ps
module pwg_release_pick
  import pwg_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int AGE_W = 16
) (
  input  logic [1:0]       win,
  input  logic [AGE_W-1:0] age_limit,
  input  logic             req_vld,
  input  logic             req_crit,
  input  logic             req_kind,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             q_full,
  input  logic             head_vld,
  input  logic             head_kind,
  input  logic [TAG_W-1:0] head_tag,
  input  logic [AGE_W-1:0] head_age,
  output logic             ev_bypass,
  output logic             ev_spill,
  output logic             ev_pop,
  output logic             ev_aged,
  output logic             ev_direct,
  output logic             ev_push,
  output logic             sel_vld,
  output logic             sel_kind,
  output logic [TAG_W-1:0] sel_tag,
  output logic [1:0]       sel_cause
);
  logic in_defer;
  logic head_ok;
  logic head_old;
  logic slot_taken;

  assign in_defer   = req_vld && !req_crit;
  assign head_ok    = head_vld && pw_allows(win, head_kind);
  assign head_old   = head_vld && (head_age >= age_limit);

  assign ev_bypass  = req_vld && req_crit;
  assign ev_spill   = in_defer && q_full;
  assign slot_taken = ev_bypass || ev_spill;
  assign ev_pop     = !slot_taken && (head_ok || head_old);
  assign ev_aged    = ev_pop && !head_ok;
  assign ev_direct  = in_defer && !q_full && !head_vld && pw_allows(win, req_kind);
  assign ev_push    = in_defer && !q_full && !ev_direct;

  always_comb begin
    sel_vld   = 1'b0;
    sel_kind  = req_kind;
    sel_tag   = req_tag;
    sel_cause = CAUSE_CRIT;
    if (ev_bypass) begin
      sel_vld = 1'b1;
    end else if (ev_spill) begin
      sel_vld   = 1'b1;
      sel_cause = CAUSE_SPILL;
    end else if (ev_pop) begin
      sel_vld   = 1'b1;
      sel_kind  = head_kind;
      sel_tag   = head_tag;
      sel_cause = ev_aged ? CAUSE_AGED : CAUSE_WIN;
    end else if (ev_direct) begin
      sel_vld   = 1'b1;
      sel_cause = CAUSE_WIN;
    end
  end
endmodule

// File: rtl/pwg_txn_gate.sv
`timescale 1ns/1ps
module pwg_txn_gate
  import pwg_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int AGE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       use_msg,
  input  logic [1:0]                 wire_win,
  input  logic                       msg_vld,
  input  logic [1:0]                 msg_win,
  input  logic [AGE_W-1:0]           age_limit,
  input  logic                       req_vld,
  input  logic                       req_crit,
  input  logic                       req_kind,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       gnt_vld,
  output logic                       gnt_kind,
  output logic [TAG_W-1:0]           gnt_tag,
  output logic [1:0]                 gnt_cause,
  output logic [1:0]                 win_now,
  output logic [$clog2(DEPTH+1)-1:0] q_count,
  output logic                       q_overflow
);
  logic             head_vld, head_kind, q_full;
  logic [TAG_W-1:0] head_tag;
  logic [AGE_W-1:0] head_age;
  logic             ev_bypass, ev_spill, ev_pop, ev_aged, ev_direct, ev_push;
  logic             sel_vld, sel_kind;
  logic [TAG_W-1:0] sel_tag;
  logic [1:0]       sel_cause;

  pwg_window_src u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .use_msg  (use_msg),
    .wire_win (wire_win),
    .msg_vld  (msg_vld),
    .msg_win  (msg_win),
    .win_now  (win_now)
  );

  pwg_defer_fifo #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .push_tag  (req_tag),
    .push_kind (req_kind),
    .pop       (ev_pop),
    .head_vld  (head_vld),
    .head_tag  (head_tag),
    .head_kind (head_kind),
    .head_age  (head_age),
    .count     (q_count),
    .full      (q_full)
  );

  pwg_release_pick #(.TAG_W(TAG_W), .AGE_W(AGE_W)) u_pick (
    .win       (win_now),
    .age_limit (age_limit),
    .req_vld   (req_vld),
    .req_crit  (req_crit),
    .req_kind  (req_kind),
    .req_tag   (req_tag),
    .q_full    (q_full),
    .head_vld  (head_vld),
    .head_kind (head_kind),
    .head_tag  (head_tag),
    .head_age  (head_age),
    .ev_bypass (ev_bypass),
    .ev_spill  (ev_spill),
    .ev_pop    (ev_pop),
    .ev_aged   (ev_aged),
    .ev_direct (ev_direct),
    .ev_push   (ev_push),
    .sel_vld   (sel_vld),
    .sel_kind  (sel_kind),
    .sel_tag   (sel_tag),
    .sel_cause (sel_cause)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_vld    <= 1'b0;
      gnt_kind   <= 1'b0;
      gnt_tag    <= '0;
      gnt_cause  <= CAUSE_CRIT;
      q_overflow <= 1'b0;
    end else begin
      gnt_vld   <= sel_vld;
      gnt_kind  <= sel_kind;
      gnt_tag   <= sel_tag;
      gnt_cause <= sel_cause;
      if (ev_spill) q_overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/pwg_txn_gate_chk.sv
`timescale 1ns/1ps
module pwg_txn_gate_chk
  import pwg_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int AGE_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_vld,
  input logic                       req_crit,
  input logic [TAG_W-1:0]           req_tag,
  input logic                       gnt_vld,
  input logic                       gnt_kind,
  input logic [TAG_W-1:0]           gnt_tag,
  input logic [1:0]                 gnt_cause,
  input logic [1:0]                 win_now,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                       q_overflow,
  input logic                       ev_bypass,
  input logic                       ev_spill,
  input logic                       ev_pop,
  input logic                       ev_aged,
  input logic                       ev_direct,
  input logic                       ev_push
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  AST_CRIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_crit |=> gnt_vld && gnt_cause == CAUSE_CRIT && gnt_tag == $past(req_tag)); // R1
  AST_NO_WIN_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld && gnt_cause == CAUSE_WIN |-> $past(win_now) != PW_IDLE); // R2
  AST_IRQ_NEEDS_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld && gnt_cause == CAUSE_WIN && gnt_kind == KIND_IRQ |-> $past(win_now) == PW_PROC); // R3
  AST_DIRECT_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_direct |-> q_count == '0); // R5
  AST_AGED_MEM_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld && gnt_cause == CAUSE_AGED && gnt_kind == KIND_MEM |-> $past(win_now) == PW_IDLE); // R8
  AST_AGED_IS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_aged |-> ev_pop); // R8
  AST_SPILL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_spill |-> q_count == CNT_W'(DEPTH)); // R9
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    q_count == CNT_W'(DEPTH) |-> !ev_push); // R9
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(q_overflow) |-> q_overflow); // R9
  AST_ONE_GRANT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_bypass, ev_spill, ev_pop, ev_direct})); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH)); // R6
endmodule

bind pwg_txn_gate pwg_txn_gate_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .req_crit   (req_crit),
  .req_tag    (req_tag),
  .gnt_vld    (gnt_vld),
  .gnt_kind   (gnt_kind),
  .gnt_tag    (gnt_tag),
  .gnt_cause  (gnt_cause),
  .win_now    (win_now),
  .q_count    (q_count),
  .q_overflow (q_overflow),
  .ev_bypass  (ev_bypass),
  .ev_spill   (ev_spill),
  .ev_pop     (ev_pop),
  .ev_aged    (ev_aged),
  .ev_direct  (ev_direct),
  .ev_push    (ev_push)
);

// File: tb/pwg_txn_gate_tb.sv
`timescale 1ns/1ps
module pwg_txn_gate_tb;
  localparam int DEPTH = 8;
  localparam int TAG_W = 8;
  localparam int AGE_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic use_msg = 1'b0;
  logic [1:0] wire_win = 2'b00;
  logic msg_vld = 1'b0;
  logic [1:0] msg_win = 2'b00;
  logic [AGE_W-1:0] age_limit = 16'd1000;
  logic req_vld = 1'b0, req_crit = 1'b0, req_kind = 1'b0;
  logic [TAG_W-1:0] req_tag = '0;
  logic gnt_vld, gnt_kind, q_overflow;
  logic [TAG_W-1:0] gnt_tag;
  logic [1:0] gnt_cause, win_now;
  logic [$clog2(DEPTH+1)-1:0] q_count;

  always #5 clk = ~clk;

  pwg_txn_gate #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .use_msg(use_msg), .wire_win(wire_win),
    .msg_vld(msg_vld), .msg_win(msg_win), .age_limit(age_limit),
    .req_vld(req_vld), .req_crit(req_crit), .req_kind(req_kind), .req_tag(req_tag),
    .gnt_vld(gnt_vld), .gnt_kind(gnt_kind), .gnt_tag(gnt_tag), .gnt_cause(gnt_cause),
    .win_now(win_now), .q_count(q_count), .q_overflow(q_overflow)
  );

  typedef struct {
    int    tag;
    int    kind;
    int    cause;
    string req;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_gnt(input int tag, input int kind, input int cause, input string req);
    exp_t e;
    e.tag = tag; e.kind = kind; e.cause = cause; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: every grant must match the next expected item
  always @(negedge clk) begin
    if (rst_n && gnt_vld) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10", "unexpected grant tag", int'(gnt_tag), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(gnt_tag) == e.tag, e.req, "grant tag", int'(gnt_tag), e.tag);
        chk(int'(gnt_kind) == e.kind, e.req, "grant kind", int'(gnt_kind), e.kind);
        chk(int'(gnt_cause) == e.cause, e.req, "grant cause", int'(gnt_cause), e.cause);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit crit, input bit kind, input int tag);
    req_vld = 1'b1; req_crit = crit; req_kind = kind; req_tag = TAG_W'(tag);
    @(negedge clk);
    req_vld = 1'b0; req_crit = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(gnt_vld == 1'b0, "R11", "gnt_vld in reset", int'(gnt_vld), 0);
    rst_n = 1'b1;
    tick(1);
    chk(q_count == 0, "R11", "q_count after reset", int'(q_count), 0);
    chk(q_overflow == 1'b0, "R11", "overflow after reset", int'(q_overflow), 0);
    chk(win_now == 2'b00, "R11", "window after reset", int'(win_now), 0);

    // R1: urgent requests pass in idle
    expect_gnt(8'h11, 0, 0, "R1");
    send(1'b1, 1'b0, 8'h11);
    chk(gnt_vld && gnt_tag == 8'h11, "R1", "urgent mem next cycle", int'(gnt_tag), 8'h11);
    expect_gnt(8'h12, 1, 0, "R1");
    send(1'b1, 1'b1, 8'h12);
    chk(gnt_vld && gnt_tag == 8'h12, "R1", "urgent irq next cycle", int'(gnt_tag), 8'h12);

    // R2/R5: deferrable requests held in idle
    send(1'b0, 1'b0, 8'h21);
    send(1'b0, 1'b0, 8'h22);
    send(1'b0, 1'b1, 8'h23);
    send(1'b0, 1'b0, 8'h24);
    tick(4);
    chk(q_count == 4, "R2", "held in idle", int'(q_count), 4);

    // R3/R6/R7: flush window drains memory until interrupt head blocks
    expect_gnt(8'h21, 0, 1, "R7");
    expect_gnt(8'h22, 0, 1, "R7");
    wire_win = 2'b01;
    tick(2);
    chk(gnt_vld && gnt_tag == 8'h21, "R7", "first burst grant", int'(gnt_tag), 8'h21);
    tick(1);
    chk(gnt_vld && gnt_tag == 8'h22, "R7", "second grant back-to-back", int'(gnt_tag), 8'h22);
    tick(1);
    chk(gnt_vld == 1'b0, "R6", "irq head blocks in flush", int'(gnt_vld), 0);
    chk(q_count == 2, "R6", "entries left behind irq", int'(q_count), 2);
    send(1'b0, 1'b0, 8'h25);
    chk(q_count == 3, "R6", "new deferrable queued behind", int'(q_count), 3);

    expect_gnt(8'h23, 1, 1, "R3");
    expect_gnt(8'h24, 0, 1, "R6");
    expect_gnt(8'h25, 0, 1, "R6");
    wire_win = 2'b10;
    tick(2);
    chk(gnt_vld && gnt_tag == 8'h23, "R3", "irq released in active", int'(gnt_tag), 8'h23);
    tick(2);
    chk(gnt_vld && gnt_tag == 8'h25, "R6", "order kept", int'(gnt_tag), 8'h25);
    tick(1);
    chk(q_count == 0, "R6", "queue drained", int'(q_count), 0);

    // R5: direct grant with empty queue in a permitting window
    expect_gnt(8'h31, 1, 1, "R5");
    send(1'b0, 1'b1, 8'h31);
    chk(gnt_vld && gnt_cause == 2'd1, "R5", "direct deferrable grant", int'(gnt_cause), 1);
    wire_win = 2'b01;
    tick(2);
    send(1'b0, 1'b1, 8'h32);
    chk(gnt_vld == 1'b0 && q_count == 1, "R3", "irq held in flush", int'(q_count), 1);
    expect_gnt(8'h32, 1, 1, "R3");
    wire_win = 2'b10;
    tick(2);
    chk(gnt_vld && gnt_tag == 8'h32, "R3", "held irq released", int'(gnt_tag), 8'h32);

    // R10: urgent request takes the slot during a drain
    wire_win = 2'b00;
    tick(2);
    send(1'b0, 1'b0, 8'h41);
    send(1'b0, 1'b0, 8'h42);
    send(1'b0, 1'b0, 8'h43);
    expect_gnt(8'h44, 0, 0, "R10");
    expect_gnt(8'h41, 0, 1, "R10");
    expect_gnt(8'h42, 0, 1, "R10");
    expect_gnt(8'h43, 0, 1, "R10");
    wire_win = 2'b01;
    tick(1);
    send(1'b1, 1'b0, 8'h44);
    chk(gnt_vld && gnt_tag == 8'h44, "R10", "urgent wins slot", int'(gnt_tag), 8'h44);
    tick(1);
    chk(gnt_vld && gnt_tag == 8'h41, "R10", "drain resumes", int'(gnt_tag), 8'h41);
    tick(3);
    chk(q_count == 0, "R10", "queue empty", int'(q_count), 0);

    // R8: aged release in idle at E+limit+1
    wire_win = 2'b00;
    tick(2);
    age_limit = 16'd5;
    expect_gnt(8'h51, 0, 2, "R8");
    send(1'b0, 1'b0, 8'h51);
    tick(5);
    chk(gnt_vld == 1'b0, "R8", "not released before limit", int'(gnt_vld), 0);
    tick(1);
    chk(gnt_vld && gnt_cause == 2'd2, "R8", "aged release", int'(gnt_cause), 2);

    // R9: overflow bypass and sticky flag
    age_limit = 16'd1000;
    for (int i = 0; i < DEPTH; i++) send(1'b0, 1'b0, 8'h60 + i);
    chk(q_count == DEPTH, "R9", "queue full", int'(q_count), DEPTH);
    chk(q_overflow == 1'b0, "R9", "no overflow yet", int'(q_overflow), 0);
    expect_gnt(8'h68, 0, 3, "R9");
    send(1'b0, 1'b0, 8'h68);
    chk(gnt_vld && gnt_cause == 2'd3, "R9", "spill grant", int'(gnt_cause), 3);
    chk(q_overflow == 1'b1, "R9", "overflow set", int'(q_overflow), 1);
    expect_gnt(8'h69, 0, 0, "R1");
    send(1'b1, 1'b0, 8'h69);
    chk(gnt_vld && gnt_cause == 2'd0, "R1", "urgent at full queue", int'(gnt_cause), 0);
    for (int i = 0; i < DEPTH; i++) expect_gnt(8'h60 + i, 0, 1, "R9");
    wire_win = 2'b10;
    tick(12);
    chk(q_count == 0, "R9", "drained after overflow", int'(q_count), 0);
    chk(q_overflow == 1'b1, "R9", "overflow sticky", int'(q_overflow), 1);

    // R4: message source
    use_msg = 1'b1;
    tick(1);
    chk(win_now == 2'b00, "R4", "message window idle, wire ignored", int'(win_now), 0);
    send(1'b0, 1'b0, 8'h71);
    chk(gnt_vld == 1'b0 && q_count == 1, "R4", "held under message idle", int'(q_count), 1);
    expect_gnt(8'h71, 0, 1, "R4");
    msg_vld = 1'b1; msg_win = 2'b01;
    tick(1);
    msg_vld = 1'b0;
    chk(win_now == 2'b01, "R4", "message selects flush", int'(win_now), 1);
    tick(1);
    chk(gnt_vld && gnt_tag == 8'h71, "R4", "release under message window", int'(gnt_tag), 8'h71);
    wire_win = 2'b00;
    tick(2);
    chk(win_now == 2'b01, "R4", "wire change ignored", int'(win_now), 1);
    msg_vld = 1'b1; msg_win = 2'b11;
    tick(1);
    msg_vld = 1'b0;
    chk(win_now == 2'b00, "R2", "code 11 taken as idle", int'(win_now), 0);
    use_msg = 1'b0; wire_win = 2'b01;
    tick(1);
    chk(win_now == 2'b01, "R4", "wire source followed", int'(win_now), 1);

    tick(3);
    chk(sb.size() == 0, "R6", "all expected grants seen", sb.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule